// File: doc/BRIEF.md
# Element-Width-Aware SIMD Predicated Merge

This block merges a source word into a destination word one 8-bit partition at a time, under control of per-lane predicate bits. A runtime element-width code says how wide each SIMD lane is: 8, 16, 32 or 64 bits. The block copies each lane's predicate bit into every partition that the lane covers. This gives an eight-bit partition enable mask, so a single bank of byte-wide multiplexers serves all four element sizes.

The enable mask can also model nested predication. The widened condition is combined with an enclosing (parent) partition mask. For the "then" arm the condition is ANDed with the parent. For the "else" arm the condition is inverted first and then ANDed with the parent. The merged word is offered either straight from the multiplexers or from an output register loaded on every rising clock edge. A mode input chooses between the two.

Top module: `simd_pred_merge`

## Requirements
- R1: The 64-bit word is split into eight partitions, partition p being bits [8p+7:8p]. When a partition is enabled, it takes the source bits. Every other partition keeps the destination bits.
- R2: `elWidth` encodes the lane size as 2'b00 for 8 bits, 2'b01 for 16, 2'b10 for 32 and 2'b11 for 64. Partition p belongs to lane p >> elWidth, and its condition bit is lanePred[p >> elWidth].
- R3: Bits of `lanePred` at index 8 >> elWidth and above have no effect on the mask or on the merged word.
- R4: With `elseArm` = 0, the enable mask is parentMask AND the widened condition.
- R5: With `elseArm` = 1, the enable mask is parentMask AND NOT the widened condition.
- R6: With `regMode` = 1, `mergeOut` shows the merge computed from the inputs present at the latest rising clock edge. With `regMode` = 0, it shows the merge of the current inputs without delay.
- R7: A synchronous active-high `rst` clears the output register, so with `regMode` = 1 `mergeOut` reads zero after a reset edge.
- R8: `partMask` always presents the current enable mask combinationally, in both output modes.
- R9: With 16-bit lanes, lanePred[3:0] = 4'b1010 and parentMask = 8'hFF, the mask for partitions 0..7 is 0,0,1,1,0,0,1,1, which is 8'hCC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| dstWord | input | 64 | Destination word, kept in disabled partitions |
| srcWord | input | 64 | Source word, written into enabled partitions |
| elWidth | input | 2 | Lane size code (00=8, 01=16, 10=32, 11=64 bits) |
| lanePred | input | 8 | One predicate bit per lane; upper bits unused at wide lanes |
| parentMask | input | 8 | Enclosing partition mask, one bit per partition |
| elseArm | input | 1 | 0 selects the then-arm mask, 1 the else-arm mask |
| regMode | input | 1 | 1 routes the registered merge to the output |
| mergeOut | output | 64 | Merged word |
| partMask | output | 8 | Effective partition enable mask |

## Verification
A fault in the widening logic shows as a wrong `partMask` in the same cycle. It also shows as whole byte groups of `mergeOut` that take the wrong operand, and the shape of the group reveals which lane index was decoded wrongly. A corrupted output register only shows in registered mode, one edge after the inputs that should have loaded it. So each registered check samples just after that edge, with the inputs still held. Parent masks and both arms are drawn at random across every lane size. This makes a swapped AND/NOT or a misplaced lane boundary appear within a few transactions.

// File: rtl/simd_merge_pkg.sv
package simd_merge_pkg;
  parameter int PART_W    = 8;
  parameter int NUM_PARTS = 8;
  localparam int DATA_W   = PART_W * NUM_PARTS;
  localparam int IDX_W    = $clog2(NUM_PARTS);
  localparam int EW_W     = $clog2(IDX_W + 1);

  typedef struct packed {
    logic [NUM_PARTS-1:0] partEn;
    logic                 regSel;
  } merge_strobe_t;
endpackage

// File: rtl/pred_mask_ctrl.sv
module pred_mask_ctrl
  import simd_merge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EW_W-1:0]      elWidth,
  input  logic [NUM_PARTS-1:0] lanePred,
  input  logic [NUM_PARTS-1:0] parentMask,
  input  logic                 elseArm,
  input  logic                 regMode,
  output merge_strobe_t        strobe
);
  logic [NUM_PARTS-1:0] condMask;

  // widen each lane predicate over the partitions of its lane
  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_widen
    logic [IDX_W-1:0] laneIdx;
    always_comb begin
      laneIdx     = IDX_W'(p) >> elWidth;
      condMask[p] = lanePred[laneIdx];
    end
  end

  always_comb begin
    strobe.regSel = regMode;
    if (elseArm) strobe.partEn = parentMask & ~condMask;
    else         strobe.partEn = parentMask & condMask;
  end

  // R4/R5: no enable outside the enclosing mask
  a_r4_within_parent: assert property (@(posedge clk) disable iff (rst)
    (strobe.partEn & ~parentMask) == '0);

  // R5: else arm never enables a partition whose condition is true
  a_r5_else_disjoint: assert property (@(posedge clk) disable iff (rst)
    elseArm |-> ((strobe.partEn & condMask) == '0));

  // R2: a single 64-bit lane enables all partitions or none
  a_r2_wide_uniform: assert property (@(posedge clk) disable iff (rst)
    (elWidth == 2'b11 && parentMask == '1) |->
      ($countones(strobe.partEn) == 0 || $countones(strobe.partEn) == NUM_PARTS));
endmodule

// File: rtl/merge_datapath.sv
module merge_datapath
  import simd_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  merge_strobe_t     strobe,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] srcWord,
  output logic [DATA_W-1:0] mergeOut
);
  logic [DATA_W-1:0] combWord;
  logic [DATA_W-1:0] regWord;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    always_comb begin
      if (strobe.partEn[p]) combWord[p*PART_W +: PART_W] = srcWord[p*PART_W +: PART_W];
      else                  combWord[p*PART_W +: PART_W] = dstWord[p*PART_W +: PART_W];
    end

    // R1: a disabled partition of the direct path shows the destination
    a_r1_keep_dst: assert property (@(posedge clk) disable iff (rst)
      (!strobe.partEn[p] && !strobe.regSel) |->
        (mergeOut[p*PART_W +: PART_W] == dstWord[p*PART_W +: PART_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) regWord <= '0;
    else     regWord <= combWord;
  end

  always_comb mergeOut = strobe.regSel ? regWord : combWord;

  // R6: registered mode presents last edge's merge
  a_r6_reg_delay: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (regWord == $past(combWord)));
endmodule

// File: rtl/simd_pred_merge.sv
module simd_pred_merge
  import simd_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [EW_W-1:0]   elWidth,
  input  logic [NUM_PARTS-1:0] lanePred,
  input  logic [NUM_PARTS-1:0] parentMask,
  input  logic              elseArm,
  input  logic              regMode,
  output logic [DATA_W-1:0] mergeOut,
  output logic [NUM_PARTS-1:0] partMask
);
  merge_strobe_t strobe;

  pred_mask_ctrl u_ctrl (
    .clk(clk), .rst(rst), .elWidth(elWidth), .lanePred(lanePred),
    .parentMask(parentMask), .elseArm(elseArm), .regMode(regMode),
    .strobe(strobe)
  );

  merge_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dstWord(dstWord),
    .srcWord(srcWord), .mergeOut(mergeOut)
  );

  always_comb partMask = strobe.partEn;
endmodule

// File: tb/sim_simd_pred_merge.sv
`timescale 1ns/1ps
module sim_simd_pred_merge;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] dstWord, srcWord;
  logic [1:0]  elWidth;
  logic [7:0]  lanePred, parentMask;
  logic        elseArm, regMode;
  logic [63:0] mergeOut;
  logic [7:0]  partMask;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  simd_pred_merge u0 (
    .clk(clk), .rst(rst), .dstWord(dstWord), .srcWord(srcWord),
    .elWidth(elWidth), .lanePred(lanePred), .parentMask(parentMask),
    .elseArm(elseArm), .regMode(regMode), .mergeOut(mergeOut), .partMask(partMask)
  );

  function automatic logic [7:0] refMask(input logic [1:0] ew, input logic [7:0] pred,
                                         input logic [7:0] par, input logic els);
    logic [7:0] c;
    for (int p = 0; p < 8; p++) c[p] = pred[p >> ew];
    return els ? (par & ~c) : (par & c);
  endfunction

  function automatic logic [63:0] refMerge(input logic [7:0] m, input logic [63:0] d,
                                           input logic [63:0] s);
    logic [63:0] r;
    for (int p = 0; p < 8; p++) r[p*8 +: 8] = m[p] ? s[p*8 +: 8] : d[p*8 +: 8];
    return r;
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ew, input logic [7:0] pred, input logic [7:0] par,
                       input logic els, input logic [63:0] d, input logic [63:0] s,
                       input logic rm);
    @(negedge clk);
    elWidth = ew; lanePred = pred; parentMask = par; elseArm = els;
    dstWord = d; srcWord = s; regMode = rm;
  endtask

  // direct path: check mid-cycle; registered: check just after the next edge
  task automatic txn(input string req, input logic [1:0] ew, input logic [7:0] pred,
                     input logic [7:0] par, input logic els, input logic [63:0] d,
                     input logic [63:0] s, input logic rm);
    logic [7:0]  m;
    m = refMask(ew, pred, par, els);
    drive(ew, pred, par, els, d, s, rm);
    if (rm) begin
      @(posedge clk); #1;
    end else #1;
    chk64({req, "/R8 mask"}, {56'd0, partMask}, {56'd0, m});
    chk64(req, mergeOut, refMerge(m, d, s));
  endtask

  initial begin
    rst = 1'b1;
    drive(2'b00, 8'h00, 8'h00, 1'b0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1);
    repeat (3) @(posedge clk);
    #1 chk64("R7 reset", mergeOut, 64'd0);
    @(negedge clk); rst = 1'b0;

    // R9 16-bit example
    txn("R9", 2'b01, 8'b0000_1010, 8'hFF, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    chk64("R9 pattern", {56'd0, partMask}, 64'h00CC);
    // R3 upper predicate bits ignored at 64-bit lanes and 32-bit lanes
    txn("R3", 2'b11, 8'hFE, 8'hFF, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
    chk64("R3 mask zero", {56'd0, partMask}, 64'd0);
    txn("R3", 2'b10, 8'hFD, 8'hFF, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0);
    chk64("R3 low lane", {56'd0, partMask}, 64'h000F);
    // R1 per-byte lanes, R4/R5 both arms with a parent mask
    txn("R1", 2'b00, 8'hA5, 8'hFF, 1'b0, 64'h0, 64'h0807_0605_0403_0201, 1'b0);
    txn("R4", 2'b00, 8'hFF, 8'h3C, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    txn("R5", 2'b01, 8'h05, 8'hF0, 1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // R6 registered path
    txn("R6", 2'b10, 8'h02, 8'hFF, 1'b0, 64'h1, 64'hDEAD_BEEF_0000_0000, 1'b1);
    txn("R6", 2'b11, 8'h01, 8'hFF, 1'b1, 64'h77, 64'h99, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] ew = 2'($urandom);
      logic rm = 1'($urandom);
      txn(rm ? "R6 rand" : "R2 rand", ew, 8'($urandom), 8'($urandom), 1'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom}, rm);
    end

    // R7 reset mid-run
    drive(2'b00, 8'hFF, 8'hFF, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rst = 1'b1;
    @(posedge clk); #1 chk64("R7 sync clear", mergeOut, 64'd0);
    @(negedge clk); rst = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule